// File: doc/BRIEF.md
# Multi-processor mailbox controller

This block lets up to four processors pass short messages to one another over eight channels. Every channel owns an eight-byte message slot held in the block. A sender fills the slot of a channel, clears any stale pending bit the target may still hold for that channel, sets the channel's bit in the target's enable register (keeping the other bits of that register), and then writes the channel's bit to the shared trigger register. The trigger raises the channel as pending only for processors that have the channel enabled. Each processor sees its own pending-status register and its own interrupt line.

The receiver reads its pending status, fetches the message from the slot, clears the pending bit through its clear register and clears the channel's bit in its own enable register. The sender polls that enable bit; once it reads back as zero the delivery is complete. All accesses use one byte-wide register port: a write takes effect at the edge that accepts it, and a read returns its byte one cycle later. A small response state machine has two states: `ST_IDLE` (no read data presented) and `ST_RESP` (read data valid). It moves from `ST_IDLE` to `ST_RESP` when a read is accepted, stays in `ST_RESP` when another read follows straight away, and returns from `ST_RESP` to `ST_IDLE` on any cycle without a read.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset every enable register, every pending-status register and every slot byte reads as zero, and every interrupt output is low.
- R2: The slot byte of channel n, byte b (b = 0 is the least significant byte) lives at offset 0x400 + 8·n + b; a write stores the byte and a later read returns it.
- R3: Processor c owns an enable register at offset 4·c whose bit n enables channel n toward that processor; writes replace the whole register and reads return it.
- R4: A write to the trigger register at offset 0x60 with bit n set sets pending bit n of every processor whose enable bit n is set at that time.
- R5: Zero bits of a trigger write, and trigger bits of channels no processor has enabled, change no pending bit.
- R6: A write to processor c's clear register at offset 0x10 + 16·c with bit n set clears pending bit n of that processor only; zero bits change nothing.
- R7: Processor c's pending status reads at offset 0x18 + 16·c; writes to that offset are ignored.
- R8: Interrupt output c is high exactly while processor c has any pending bit set, so it rises in the cycle after the accepting edge of a trigger write and stays high until the last pending bit is cleared.
- R9: Reads of any offset other than enable, pending-status and slot locations (including the trigger and clear registers) return zero, and writes to unmapped offsets change no state.
- R10: A read accepted at a clock edge presents its byte on the read-data output with the valid flag high during the following cycle; the flag is low in any cycle that does not follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte offset of the access |
| req_wdata | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data valid (cycle after an accepted read) |
| rd_data | output | 8 | Read data byte |
| irq | output | 4 | One interrupt line per processor |

## Verification
Writes to enable, clear, trigger and slot locations act at the edge that accepts them, and an interrupt line follows its pending bits in the same cycle, so its change is due one cycle after the write is presented. A read is answered one cycle after it is presented, together with the valid flag. The bench presents every access on a falling edge and samples outputs on the next falling edge, half a period after the accepting edge, so every result is read in the first cycle it is due.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_AW       = 11;
    localparam int unsigned MBX_DW       = 8;
    localparam int unsigned SLOT_BYTES   = 8;
    localparam int unsigned SLOT_BASE    = 32'h400;
    localparam int unsigned TRIG_OFFSET  = 32'h060;
    localparam int unsigned GROUP_STRIDE = 16;
    localparam int unsigned EN_STRIDE    = 4;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_EN,
        ACC_CLR,
        ACC_PEND,
        ACC_TRIG,
        ACC_SLOT
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [1:0]  cpu;
        logic [5:0]  sidx;
    } acc_dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rsp_state_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_CPU = 4
) (
    input  logic [MBX_AW-1:0] addr,
    output acc_dec_t          dec
);

    localparam int unsigned SLOT_END = SLOT_BASE + NUM_CH * SLOT_BYTES;

    logic [31:0] a_w;
    logic [31:0] grp_w;

    assign a_w   = 32'(addr);
    assign grp_w = a_w / GROUP_STRIDE;

    always_comb begin
        dec      = '0;
        dec.kind = ACC_NONE;
        if (a_w >= SLOT_BASE && a_w < SLOT_END) begin
            dec.kind = ACC_SLOT;
            dec.sidx = addr[5:0];
        end else if (a_w == TRIG_OFFSET) begin
            dec.kind = ACC_TRIG;
        end else if (grp_w == 0 && addr[1:0] == 2'b00 && (a_w / EN_STRIDE) < NUM_CPU) begin
            dec.kind = ACC_EN;
            dec.cpu  = addr[3:2];
        end else if (grp_w >= 1 && grp_w <= NUM_CPU && addr[3:0] == 4'h0) begin
            dec.kind = ACC_CLR;
            dec.cpu  = 2'(grp_w - 1);
        end else if (grp_w >= 1 && grp_w <= NUM_CPU && addr[3:0] == 4'h8) begin
            dec.kind = ACC_PEND;
            dec.cpu  = 2'(grp_w - 1);
        end
    end

endmodule

// File: rtl/mbx_slot_store.sv
module mbx_slot_store
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [5:0]        widx,
    input  logic [MBX_DW-1:0] wdata,
    input  logic [5:0]        ridx,
    output logic [MBX_DW-1:0] rdata
);

    localparam int unsigned DEPTH = NUM_CH * SLOT_BYTES;

    logic [MBX_DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];

endmodule

// File: rtl/mbx_cpu_lane.sv
module mbx_cpu_lane #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              clr_we,
    input  logic              trig_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] pend_q,
    output logic              irq
);

    logic [NUM_CH-1:0] set_bits;
    logic [NUM_CH-1:0] clr_bits;

    assign set_bits = trig_we ? (wbits & en_q) : '0;
    assign clr_bits = clr_we  ? wbits          : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= wbits;
            end
            pend_q <= (pend_q & ~clr_bits) | set_bits;
        end
    end

    assign irq = |pend_q;

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_CPU = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [MBX_AW-1:0]   req_addr,
    input  logic [MBX_DW-1:0]   req_wdata,
    output logic                rd_valid,
    output logic [MBX_DW-1:0]   rd_data,
    output logic [NUM_CPU-1:0]  irq
);

    acc_dec_t          dec;
    logic              wr_acc;
    logic              rd_acc;
    logic [MBX_DW-1:0] slot_rdata;
    logic [MBX_DW-1:0] rd_mux;
    logic [MBX_DW-1:0] rd_q;
    rsp_state_e        st_q;
    rsp_state_e        st_d;

    logic [NUM_CH-1:0] en_arr   [NUM_CPU];
    logic [NUM_CH-1:0] pend_arr [NUM_CPU];

    assign wr_acc = req_valid &&  req_write;
    assign rd_acc = req_valid && !req_write;

    mbx_decode #(
        .NUM_CH  (NUM_CH),
        .NUM_CPU (NUM_CPU)
    ) u_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    mbx_slot_store #(
        .NUM_CH (NUM_CH)
    ) u_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_acc && dec.kind == ACC_SLOT),
        .widx  (dec.sidx),
        .wdata (req_wdata),
        .ridx  (dec.sidx),
        .rdata (slot_rdata)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
        mbx_cpu_lane #(
            .NUM_CH (NUM_CH)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_we   (wr_acc && dec.kind == ACC_EN  && dec.cpu == 2'(c)),
            .clr_we  (wr_acc && dec.kind == ACC_CLR && dec.cpu == 2'(c)),
            .trig_we (wr_acc && dec.kind == ACC_TRIG),
            .wbits   (req_wdata[NUM_CH-1:0]),
            .en_q    (en_arr[c]),
            .pend_q  (pend_arr[c]),
            .irq     (irq[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec.kind)
            ACC_EN:   rd_mux = MBX_DW'(en_arr[dec.cpu]);
            ACC_PEND: rd_mux = MBX_DW'(pend_arr[dec.cpu]);
            ACC_SLOT: rd_mux = slot_rdata;
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = rd_acc ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = rd_acc ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            rd_q <= '0;
        end else begin
            st_q <= st_d;
            if (rd_acc) begin
                rd_q <= rd_mux;
            end
        end
    end

    always_comb begin
        rd_valid = (st_q == ST_RESP);
        rd_data  = rd_valid ? rd_q : '0;
    end

endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [MBX_AW-1:0]  req_addr,
    input logic               rd_valid,
    input logic [MBX_DW-1:0]  rd_data,
    input logic [NUM_CPU-1:0] irq
);

    function automatic logic readable(input logic [MBX_AW-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (a == MBX_AW'(EN_STRIDE * c)) hit = 1'b1;
            if (a == MBX_AW'(GROUP_STRIDE * (c + 1) + 8)) hit = 1'b1;
        end
        if (32'(a) >= SLOT_BASE && 32'(a) < SLOT_BASE + NUM_CH * SLOT_BYTES) hit = 1'b1;
        return hit;
    endfunction

    assert_read_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_resp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !readable(req_addr)) |=> (rd_data == '0));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> $past(req_valid && req_write && req_addr == MBX_AW'(TRIG_OFFSET)));

        assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[c]) |-> $past(req_valid && req_write &&
                                     req_addr == MBX_AW'(GROUP_STRIDE * (c + 1))));
    end

endmodule

bind mbx_ctrl mbx_ctrl_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_CPU (NUM_CPU)
) u_mbx_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .irq       (irq)
);

// File: tb/mbx_ctrl_bench.sv
module mbx_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [3:0]  irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    logic [7:0] en_m [4];

    always #4 clk = ~clk;

    mbx_ctrl u_mbx_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'(addr); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [7:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 11'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic rd_check(input string req, input int addr, input logic [7:0] exp);
        logic [7:0] d;
        logic v;
        rd(addr, d, v);
        check({req, " valid"}, 8'(v), 8'h01);
        check(req, d, exp);
    endtask

    function automatic logic [7:0] pat(input int c);
        logic [7:0] p;
        p = 8'h93;
        return (p << c) | (p >> (8 - c));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rem;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", 8'(irq), 8'h00);
        for (int c = 0; c < 4; c++) begin
            rd_check("R1 enable", 4 * c, 8'h00);
            rd_check("R1 pending", 'h18 + 16 * c, 8'h00);
        end
        for (int i = 0; i < 64; i++) rd_check("R1 slot", 'h400 + i, 8'h00);

        // R10: valid flag drops without a read
        @(negedge clk);
        check("R10 idle valid", 8'(rd_valid), 8'h00);

        // R2: slot storage sweep
        for (int i = 0; i < 64; i++) wr('h400 + i, 8'(i * 37 + 5));
        for (int i = 0; i < 64; i++) rd_check("R2 slot", 'h400 + i, 8'(i * 37 + 5));

        // R3: enable registers
        for (int c = 0; c < 4; c++) begin
            en_m[c] = pat(c);
            wr(4 * c, en_m[c]);
        end
        for (int c = 0; c < 4; c++) rd_check("R3 enable", 4 * c, en_m[c]);

        // R4 / R5 / R8 / R6: single-channel trigger sweep
        for (int n = 0; n < 8; n++) begin
            wr('h60, 8'(1 << n));
            for (int c = 0; c < 4; c++) begin
                check("R8 irq after trigger", 8'(irq[c]), 8'(en_m[c][n]));
                rd_check("R4 pending", 'h18 + 16 * c, en_m[c] & 8'(1 << n));
            end
            for (int c = 0; c < 4; c++) wr('h10 + 16 * c, 8'hff);
            check("R6 irq after clear", 8'(irq), 8'h00);
        end

        // R5: zero trigger bits
        wr('h60, 8'h00);
        check("R5 irq zero trigger", 8'(irq), 8'h00);
        for (int c = 0; c < 4; c++) rd_check("R5 pending", 'h18 + 16 * c, 8'h00);

        // R5: channel enabled nowhere
        wr(0, 8'h00); wr(4, 8'h00); wr(8, 8'h00); wr(12, 8'h01);
        wr('h60, 8'h80);
        check("R5 disabled channel irq", 8'(irq), 8'h00);
        for (int c = 0; c < 4; c++) wr(4 * c, en_m[c]);

        // All channels triggered
        wr('h60, 8'hff);
        for (int c = 0; c < 4; c++) rd_check("R4 full trigger", 'h18 + 16 * c, en_m[c]);

        // R7: pending status not writable
        wr('h18, 8'h00);
        rd_check("R7 pending write ignored", 'h18, en_m[0]);

        // R6: zero clear bits
        wr('h10, 8'h00);
        rd_check("R6 zero clear", 'h18, en_m[0]);

        // R8 / R6: drain processor 0 one bit at a time
        rem = en_m[0];
        for (int n = 0; n < 8; n++) begin
            if (en_m[0][n]) begin
                wr('h10, 8'(1 << n));
                rem[n] = 1'b0;
                check("R8 irq while bits remain", 8'(irq[0]), 8'(rem != 0));
                check("R6 other processor kept", 8'(irq[1]), 8'h01);
            end
        end
        rd_check("R6 pending other processor", 'h28, en_m[1]);
        for (int c = 1; c < 4; c++) wr('h10 + 16 * c, 8'hff);
        check("R6 all cleared", 8'(irq), 8'h00);

        // R9: unmapped reads and writes
        foreach (en_m[k]) begin end
        rd_check("R9 unmapped", 'h001, 8'h00);
        rd_check("R9 unmapped", 'h014, 8'h00);
        rd_check("R9 clear reads zero", 'h010, 8'h00);
        rd_check("R9 unmapped", 'h050, 8'h00);
        rd_check("R9 trigger reads zero", 'h060, 8'h00);
        rd_check("R9 unmapped", 'h070, 8'h00);
        rd_check("R9 unmapped", 'h3ff, 8'h00);
        rd_check("R9 past slots", 'h440, 8'h00);
        rd_check("R9 unmapped", 'h7ff, 8'h00);
        wr('h001, 8'h5a);
        wr('h440, 8'h5a);
        rd_check("R9 write ignored", 'h000, en_m[0]);
        rd_check("R9 slot untouched", 'h43f, 8'(63 * 37 + 5));

        // Full send and acknowledge: channel 3 toward processor 1
        for (int c = 0; c < 4; c++) wr(4 * c, 8'h00);
        for (int b = 0; b < 8; b++) wr('h400 + 24 + b, 8'(8'hc0 + b));
        wr('h20, 8'h08);
        rd_check("R3 target enable before send", 'h04, 8'h00);
        wr('h04, 8'h08);
        wr('h60, 8'h08);
        check("R4 target irq only", 8'(irq), 8'h02);
        rd_check("R4 target pending", 'h28, 8'h08);
        for (int b = 0; b < 8; b++) rd_check("R2 message byte", 'h400 + 24 + b, 8'(8'hc0 + b));
        wr('h20, 8'h08);
        check("R8 irq after ack", 8'(irq), 8'h00);
        wr('h04, 8'h00);
        rd_check("R3 sender sees done", 'h04, 8'h00);

        // R10: back-to-back reads each answered
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h400;
        @(negedge clk);
        check("R10 first valid", 8'(rd_valid), 8'h01);
        check("R10 first data", rd_data, 8'h05);
        req_addr = 11'h401;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 second valid", 8'(rd_valid), 8'h01);
        check("R10 second data", rd_data, 8'(37 + 5));
        @(negedge clk);
        check("R10 valid drops", 8'(rd_valid), 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule